// File: doc/BRIEF.md
# SPI Flash Passthrough Filter

This block sits on the SPI path between an upstream host and a downstream serial flash. While passthrough is enabled it relays the host's serial clock, chip select and four data lanes to the flash pins, and relays the flash's four lanes back to the host. Relay is combinational, so every bit reaches the other side in the same cycle. A control section oversamples the host clock with the system clock and follows each command through its phases: opcode, address and payload.

Once the eight opcode bits have arrived, the block presents the opcode together with a one-cycle strobe. External decode logic answers in that same cycle with the command's attributes. The attributes say how wide the address is, whether to substitute a configured address, whether to patch the first payload bits from a mask and a pattern, which lanes carry payload and in which direction, and whether to block the command. A blocked command is removed from the flash's view by forcing its chip select inactive until the host ends the transaction. The host clock must stay in each level for at least two system clock cycles.

Top module: `ppPassFilter`

## Requirements
- R1: With `ptEnable` low, `flashSck`=0, `flashCsb`=1, `flashSckEn`=`flashCsbEn`=0, `flashData`=0, `flashDataEn`=0 and `hostDataIn`=0, whatever the host does.
- R2: With `ptEnable` high, `flashSck` follows `hostSck`, `flashCsb` follows `hostCsb` (unless dropped, R9), both pin enables are 1, and `hostDataIn` equals `flashDataIn` on all four lanes.
- R3: Opcode bits are taken MSB first from lane 0 on each rising `hostSck` while `hostCsb` is low. This works with either clock idle level (SPI mode 0 or 3). After the eighth bit, `opcodeValid` is high for exactly one cycle with `cmdOpcode` holding the opcode.
- R4: The decode inputs are captured in the `opcodeValid` cycle. `addrMode` 0 means no address, 1 means 32 bits if `addr4bEn` else 24 bits, 2 means 24 bits and 3 means 32 bits.
- R5: With `addrSwapEn` captured, for an N-bit address (N=24 or 32), downstream lane 0 carries `swapAddr[N-1-k]` at address bit k instead of the host's bit.
- R6: With payload patching active, payload bit j (j < 32, counted from the first bit after the address) leaves as `(swapMask[31-j] & swapData[31-j]) | (~swapMask[31-j] & host bit)`. Later bits pass unchanged.
- R7: Payload patching takes effect only if `payloadLanes` = 4'b0001 and `payloadDirOut` = 0 (host to flash). Otherwise lane 0 passes unchanged.
- R8: `flashDataEn` is 4'b0001 during opcode and address. In the payload it equals `payloadLanes` when `payloadDirOut`=0 and 4'b0000 when it is 1. It is 4'b0000 while `hostCsb` is high.
- R9: If `dropCmd` is captured high, `flashCsb` is 1, `flashData` is 0 and `flashDataEn` is 0 from the next cycle until `hostCsb` rises.
- R10: Lanes 1 to 3 from the host reach `flashData[3:1]` unchanged during opcode, address and payload of a command that is not dropped.
- R11: Raising `hostCsb` discards the command state, so the next transaction starts with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ptEnable | input | 1 | Passthrough enable |
| hostSck | input | 1 | Serial clock from host |
| hostCsb | input | 1 | Chip select from host, active low |
| hostDataOut | input | 4 | Data lanes driven by host |
| hostDataIn | output | 4 | Data lanes returned to host |
| flashSck | output | 1 | Serial clock to flash |
| flashSckEn | output | 1 | Output enable for flash clock pin |
| flashCsb | output | 1 | Chip select to flash, active low |
| flashCsbEn | output | 1 | Output enable for flash chip select pin |
| flashData | output | 4 | Data lanes to flash |
| flashDataEn | output | 4 | Per-lane output enables to flash |
| flashDataIn | input | 4 | Data lanes driven by flash |
| cmdOpcode | output | 8 | Received opcode |
| opcodeValid | output | 1 | One-cycle strobe once the opcode is complete |
| addrMode | input | 2 | Address size selector (R4) |
| addr4bEn | input | 1 | Picks 32-bit address when addrMode is 1 |
| addrSwapEn | input | 1 | Substitute the address |
| payloadSwapEn | input | 1 | Patch the first payload bits |
| payloadLanes | input | 4 | Lanes used by the payload |
| payloadDirOut | input | 1 | 1: payload flows flash to host |
| dropCmd | input | 1 | Block this command |
| swapAddr | input | 32 | Replacement address |
| swapMask | input | 32 | Patch mask, 1 selects pattern bit |
| swapData | input | 32 | Patch pattern |

## Verification
The bench builds the block with its default 32-bit patch window, equal to the longest address. A single counter therefore serves both the 24-bit and 32-bit address cases and the patch window. At this size a payload longer than 32 bits shows the edge where patching stops. Transactions run in both clock idle levels and with every address selector value, including the configuration-dependent one. The mask and pattern mix kept and replaced bits, and the substituted address differs from the host's in every byte. A wrong address length or an off-by-one window therefore shows up on lane 0.

// File: rtl/ppFilterPkg.sv
package ppFilterPkg;

  localparam int unsigned LaneCount     = 4;
  localparam int unsigned OpcodeBits    = 8;
  localparam int unsigned ShortAddrBits = 24;
  localparam int unsigned LongAddrBits  = 32;

  typedef enum logic [2:0] {
    PhOpcode  = 3'd0,
    PhDecode  = 3'd1,
    PhAddr    = 3'd2,
    PhPayload = 3'd3,
    PhDrop    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    AmNone  = 2'd0,
    AmByCfg = 2'd1,
    Am3Byte = 2'd2,
    Am4Byte = 2'd3
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       live;
    logic       drop;
    logic       addrSwapAct;
    logic       paySwapAct;
    logic [3:0] dataEn;
  } ctrlStrobes_t;

  function automatic logic [5:0] resolveAddrBits(addrSel_e sel, logic cfg4b);
    logic [5:0] n;
    unique case (sel)
      AmNone:  n = 6'd0;
      AmByCfg: n = cfg4b ? 6'(LongAddrBits) : 6'(ShortAddrBits);
      Am3Byte: n = 6'(ShortAddrBits);
      default: n = 6'(LongAddrBits);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ppFilterCtrl.sv
module ppFilterCtrl
  import ppFilterPkg::*;
#(
  parameter int unsigned SwapBits = 32,
  localparam int unsigned MaxBits = (SwapBits > LongAddrBits) ? SwapBits : LongAddrBits,
  localparam int unsigned CntW    = $clog2(MaxBits + 1),
  localparam int unsigned IdxW    = $clog2(MaxBits)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ptEnable,
  input  logic               hostSck,
  input  logic               hostCsb,
  input  logic               hostMosi,
  input  logic [1:0]         addrMode,
  input  logic               addr4bEn,
  input  logic               addrSwapEn,
  input  logic               payloadSwapEn,
  input  logic [3:0]         payloadLanes,
  input  logic               payloadDirOut,
  input  logic               dropCmd,
  output ctrlStrobes_t       strobes,
  output logic [IdxW-1:0]    bitIdx,
  output logic [7:0]         cmdOpcode,
  output logic               opcodeValid
);

  phase_e          phase;
  logic            sckPrev;
  logic [CntW-1:0] bitCnt;
  logic [7:0]      opShift;
  logic [5:0]      addrBitsL;
  logic            addrSwapL;
  logic            paySwapL;
  logic            dirOutL;
  logic [3:0]      lanesL;

  logic live;
  logic sampleEdge;
  logic paySwapOk;
  logic [5:0] addrBitsNow;

  assign live        = ptEnable & ~hostCsb;
  assign sampleEdge  = hostSck & ~sckPrev;
  assign paySwapOk   = paySwapL & (lanesL == 4'b0001) & ~dirOutL;
  assign addrBitsNow = resolveAddrBits(addrSel_e'(addrMode), addr4bEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PhOpcode;
      sckPrev   <= 1'b0;
      bitCnt    <= '0;
      opShift   <= '0;
      addrBitsL <= '0;
      addrSwapL <= 1'b0;
      paySwapL  <= 1'b0;
      dirOutL   <= 1'b0;
      lanesL    <= '0;
    end else begin
      sckPrev <= hostSck;
      if (!live) begin
        phase  <= PhOpcode;
        bitCnt <= '0;
      end else begin
        unique case (phase)
          PhOpcode: if (sampleEdge) begin
            opShift <= {opShift[6:0], hostMosi};
            if (bitCnt == CntW'(OpcodeBits - 1)) begin
              phase  <= PhDecode;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PhDecode: begin
            addrBitsL <= addrBitsNow;
            addrSwapL <= addrSwapEn;
            paySwapL  <= payloadSwapEn;
            dirOutL   <= payloadDirOut;
            lanesL    <= payloadLanes;
            bitCnt    <= '0;
            if (dropCmd)                  phase <= PhDrop;
            else if (addrBitsNow == 6'd0) phase <= PhPayload;
            else                          phase <= PhAddr;
          end
          PhAddr: if (sampleEdge) begin
            if (bitCnt == CntW'(addrBitsL - 6'd1)) begin
              phase  <= PhPayload;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PhPayload: if (sampleEdge && bitCnt != CntW'(SwapBits)) begin
            bitCnt <= bitCnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobes.live        = live;
    strobes.drop        = live & (phase == PhDrop);
    strobes.addrSwapAct = live & (phase == PhAddr) & addrSwapL;
    strobes.paySwapAct  = live & (phase == PhPayload) & paySwapOk
                          & (bitCnt < CntW'(SwapBits));
    if (!live || phase == PhDrop)  strobes.dataEn = 4'b0000;
    else if (phase == PhPayload)   strobes.dataEn = dirOutL ? 4'b0000 : lanesL;
    else                           strobes.dataEn = 4'b0001;
    if (phase == PhAddr)
      bitIdx = IdxW'(int'(addrBitsL) - 1 - int'(bitCnt));
    else if (strobes.paySwapAct)
      bitIdx = IdxW'(int'(SwapBits) - 1 - int'(bitCnt));
    else
      bitIdx = '0;
  end

  assign cmdOpcode   = opShift;
  assign opcodeValid = live & (phase == PhDecode);

  assert_opcode_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    opcodeValid |=> !opcodeValid);

  assert_addr_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    (live && phase == PhAddr && sampleEdge && bitCnt == CntW'(addrBitsL - 6'd1))
      |=> phase == PhPayload);

  assert_patch_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (live && phase == PhPayload && sampleEdge && bitCnt == CntW'(SwapBits - 1))
      |=> !strobes.paySwapAct);

  assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PhDrop && live) |=> phase == PhDrop);

endmodule

// File: rtl/ppFilterData.sv
module ppFilterData
  import ppFilterPkg::*;
#(
  parameter int unsigned SwapBits = 32,
  localparam int unsigned MaxBits = (SwapBits > LongAddrBits) ? SwapBits : LongAddrBits,
  localparam int unsigned IdxW    = $clog2(MaxBits)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ptEnable,
  input  logic                hostSck,
  input  logic                hostCsb,
  input  logic [3:0]          hostDataOut,
  input  logic [3:0]          flashDataIn,
  input  logic [31:0]         swapAddr,
  input  logic [SwapBits-1:0] swapMask,
  input  logic [SwapBits-1:0] swapData,
  input  ctrlStrobes_t        strobes,
  input  logic [IdxW-1:0]     bitIdx,
  output logic [3:0]          hostDataIn,
  output logic                flashSck,
  output logic                flashSckEn,
  output logic                flashCsb,
  output logic                flashCsbEn,
  output logic [3:0]          flashData,
  output logic [3:0]          flashDataEn
);

  logic       lane0;
  logic [3:0] laneMux;
  logic       forward;

  always_comb begin
    lane0 = hostDataOut[0];
    if (strobes.addrSwapAct)
      lane0 = swapAddr[bitIdx[4:0]];
    else if (strobes.paySwapAct)
      lane0 = (swapMask[bitIdx] & swapData[bitIdx]) | (~swapMask[bitIdx] & hostDataOut[0]);
  end

  assign laneMux[0] = lane0;
  for (genvar g = 1; g < LaneCount; g++) begin : gUpperLane
    assign laneMux[g] = hostDataOut[g];
  end

  assign forward     = strobes.live & ~strobes.drop;
  assign flashSck    = ptEnable & hostSck;
  assign flashSckEn  = ptEnable;
  assign flashCsbEn  = ptEnable;
  assign flashCsb    = ~ptEnable | hostCsb | strobes.drop;
  assign flashData   = forward ? laneMux : 4'b0000;
  assign flashDataEn = strobes.dataEn;
  assign hostDataIn  = ptEnable ? flashDataIn : 4'b0000;

  assert_off_defaults_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ptEnable |-> (flashCsb && !flashSck && flashData == 4'b0 && flashDataEn == 4'b0
                   && hostDataIn == 4'b0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ptEnable && hostCsb) |-> (flashDataEn == 4'b0 && flashCsb));

  assert_drop_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ptEnable && !hostCsb && $past(ptEnable && !hostCsb && flashCsb)) |-> flashCsb);

endmodule

// File: rtl/ppPassFilter.sv
module ppPassFilter
  import ppFilterPkg::*;
#(
  parameter int unsigned SwapBits = 32,
  localparam int unsigned MaxBits = (SwapBits > LongAddrBits) ? SwapBits : LongAddrBits,
  localparam int unsigned IdxW    = $clog2(MaxBits)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ptEnable,
  input  logic                hostSck,
  input  logic                hostCsb,
  input  logic [3:0]          hostDataOut,
  output logic [3:0]          hostDataIn,
  output logic                flashSck,
  output logic                flashSckEn,
  output logic                flashCsb,
  output logic                flashCsbEn,
  output logic [3:0]          flashData,
  output logic [3:0]          flashDataEn,
  input  logic [3:0]          flashDataIn,
  output logic [7:0]          cmdOpcode,
  output logic                opcodeValid,
  input  logic [1:0]          addrMode,
  input  logic                addr4bEn,
  input  logic                addrSwapEn,
  input  logic                payloadSwapEn,
  input  logic [3:0]          payloadLanes,
  input  logic                payloadDirOut,
  input  logic                dropCmd,
  input  logic [31:0]         swapAddr,
  input  logic [SwapBits-1:0] swapMask,
  input  logic [SwapBits-1:0] swapData
);

  ctrlStrobes_t    strobes;
  logic [IdxW-1:0] bitIdx;

  ppFilterCtrl #(.SwapBits(SwapBits)) uCtrl (
    .clk(clk), .rstN(rstN), .ptEnable(ptEnable), .hostSck(hostSck), .hostCsb(hostCsb),
    .hostMosi(hostDataOut[0]), .addrMode(addrMode), .addr4bEn(addr4bEn),
    .addrSwapEn(addrSwapEn), .payloadSwapEn(payloadSwapEn), .payloadLanes(payloadLanes),
    .payloadDirOut(payloadDirOut), .dropCmd(dropCmd), .strobes(strobes), .bitIdx(bitIdx),
    .cmdOpcode(cmdOpcode), .opcodeValid(opcodeValid)
  );

  ppFilterData #(.SwapBits(SwapBits)) uData (
    .clk(clk), .rstN(rstN), .ptEnable(ptEnable), .hostSck(hostSck), .hostCsb(hostCsb),
    .hostDataOut(hostDataOut), .flashDataIn(flashDataIn), .swapAddr(swapAddr),
    .swapMask(swapMask), .swapData(swapData), .strobes(strobes), .bitIdx(bitIdx),
    .hostDataIn(hostDataIn), .flashSck(flashSck), .flashSckEn(flashSckEn),
    .flashCsb(flashCsb), .flashCsbEn(flashCsbEn), .flashData(flashData),
    .flashDataEn(flashDataEn)
  );

endmodule

// File: tb/ppPassFilter_test.sv
module ppPassFilter_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ptEnable = 1'b0;
  logic hostSck = 1'b0;
  logic hostCsb = 1'b1;
  logic [3:0] hostDataOut = '0;
  logic [3:0] hostDataIn;
  logic flashSck, flashSckEn, flashCsb, flashCsbEn;
  logic [3:0] flashData, flashDataEn;
  logic [3:0] flashDataIn = '0;
  logic [7:0] cmdOpcode;
  logic opcodeValid;
  logic [1:0] addrMode = '0;
  logic addr4bEn = 1'b0, addrSwapEn = 1'b0, payloadSwapEn = 1'b0;
  logic [3:0] payloadLanes = 4'b0001;
  logic payloadDirOut = 1'b0, dropCmd = 1'b0;
  logic [31:0] swapAddr = 32'hA5C3_0F96;
  logic [31:0] swapMask = 32'hFF00_F0F0;
  logic [31:0] swapData = 32'h1234_5678;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  logic [7:0] expOp = '0;
  logic expDropped = 1'b0;
  logic csbDontCare = 1'b0;
  logic monOn = 1'b0;

  always #2 clk = ~clk;

  ppPassFilter uut (
    .clk(clk), .rstN(rstN), .ptEnable(ptEnable), .hostSck(hostSck), .hostCsb(hostCsb),
    .hostDataOut(hostDataOut), .hostDataIn(hostDataIn), .flashSck(flashSck),
    .flashSckEn(flashSckEn), .flashCsb(flashCsb), .flashCsbEn(flashCsbEn),
    .flashData(flashData), .flashDataEn(flashDataEn), .flashDataIn(flashDataIn),
    .cmdOpcode(cmdOpcode), .opcodeValid(opcodeValid), .addrMode(addrMode),
    .addr4bEn(addr4bEn), .addrSwapEn(addrSwapEn), .payloadSwapEn(payloadSwapEn),
    .payloadLanes(payloadLanes), .payloadDirOut(payloadDirOut), .dropCmd(dropCmd),
    .swapAddr(swapAddr), .swapMask(swapMask), .swapData(swapData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int addrLen(input logic [1:0] m, input logic c4);
    case (m)
      2'd0: return 0;
      2'd1: return c4 ? 32 : 24;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  // every-clock comparison of the relayed pins
  always @(negedge clk) begin
    if (monOn) begin
      chk("R2 sck", 64'(flashSck), 64'(ptEnable & hostSck));
      chk("R2 return lanes", 64'(hostDataIn), ptEnable ? 64'(flashDataIn) : 64'd0);
      chk("R2 pin enables", 64'({flashSckEn, flashCsbEn}), ptEnable ? 64'd3 : 64'd0);
      if (!csbDontCare)
        chk("R9 csb", 64'(flashCsb), 64'(!ptEnable | hostCsb | expDropped));
      if (!ptEnable)
        chk("R1 data idle", 64'({flashData, flashDataEn}), 64'd0);
      if (ptEnable && hostCsb)
        chk("R8 idle enables", 64'(flashDataEn), 64'd0);
      if (opcodeValid) begin
        pulseCnt++;
        chk("R3 opcode", 64'(cmdOpcode), 64'(expOp));
      end
    end
  end

  task automatic runXfer(input bit m3, input logic [7:0] op, input logic [31:0] hAddr,
                         input int nPay, input logic [63:0] pay);
    bit q[$];
    int nA;
    int startPulses;
    bit dropNow;
    nA = addrLen(addrMode, addr4bEn);
    dropNow = dropCmd;
    for (int i = 7; i >= 0; i--) q.push_back(op[i]);
    for (int i = nA - 1; i >= 0; i--) q.push_back(hAddr[i]);
    for (int i = nPay - 1; i >= 0; i--) q.push_back(pay[i]);
    expOp = op;
    startPulses = pulseCnt;
    hostSck = m3;
    step(2);
    hostCsb = 1'b0;
    step(2);
    for (int k = 0; k < q.size(); k++) begin
      logic [2:0] up;
      logic e0;
      logic [3:0] eEn;
      string tag;
      up = 3'($urandom);
      hostSck = 1'b0;
      hostDataOut = {up, q[k]};
      flashDataIn = 4'($urandom);
      step(2);
      if (k < 8) begin
        e0 = q[k]; eEn = 4'b0001; tag = "R3 opcode lane";
      end else if (k < 8 + nA) begin
        e0 = addrSwapEn ? swapAddr[nA - 1 - (k - 8)] : q[k];
        eEn = 4'b0001; tag = "R5 R4 address lane";
      end else begin
        int j;
        j = k - 8 - nA;
        if (payloadSwapEn && payloadLanes == 4'b0001 && !payloadDirOut && j < 32)
          e0 = (swapMask[31 - j] & swapData[31 - j]) | (~swapMask[31 - j] & q[k]);
        else
          e0 = q[k];
        eEn = payloadDirOut ? 4'b0000 : payloadLanes;
        tag = "R6 R7 payload lane";
      end
      if (dropNow && k >= 8) begin
        chk("R9 dropped data", 64'({flashData, flashDataEn}), 64'd0);
      end else begin
        chk(tag, 64'(flashData[0]), 64'(e0));
        chk("R10 upper lanes", 64'(flashData[3:1]), 64'(up));
        chk("R8 lane enables", 64'(flashDataEn), 64'(eEn));
      end
      step(2);
      hostSck = 1'b1;
      if (k == 7) csbDontCare = 1'b1;
      step(4);
      if (k == 7) begin
        expDropped = dropNow;
        csbDontCare = 1'b0;
      end
    end
    if (!m3) hostSck = 1'b0;
    step(2);
    hostCsb = 1'b1;
    expDropped = 1'b0;
    step(3);
    chk("R3 one strobe per command", 64'(pulseCnt - startPulses), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    monOn = 1'b1;
    // R1: reset and disabled state, host active
    chk("R1 reset csb", 64'(flashCsb), 64'd1);
    chk("R1 reset strobe", 64'(opcodeValid), 64'd0);
    hostCsb = 1'b0;
    for (int i = 0; i < 24; i++) begin
      hostSck = ~hostSck;
      hostDataOut = 4'($urandom);
      flashDataIn = 4'($urandom);
      step(2);
      chk("R1 disabled outputs", 64'({flashSck, flashCsb, flashData, flashDataEn, hostDataIn}),
          64'({1'b0, 1'b1, 12'd0}));
    end
    hostCsb = 1'b1;
    hostSck = 1'b0;
    step(4);
    chk("R1 no opcode while disabled", 64'(pulseCnt), 64'd0);
    ptEnable = 1'b1;
    step(2);

    // mode 0 read, 24-bit address, no rewrite
    addrMode = 2'd2; payloadLanes = 4'b0010; payloadDirOut = 1'b1;
    runXfer(1'b0, 8'h0B, 32'h00C0_FFEE, 16, 64'hBEEF);

    // mode 3, 32-bit address substituted (R5)
    addrMode = 2'd3; addrSwapEn = 1'b1;
    runXfer(1'b1, 8'h13, 32'h1234_5678, 8, 64'h5A);

    // config-selected 24-bit address with swap, patched write crossing window (R4 R6)
    addrMode = 2'd1; addr4bEn = 1'b0; payloadLanes = 4'b0001; payloadDirOut = 1'b0;
    payloadSwapEn = 1'b1;
    runXfer(1'b0, 8'h02, 32'h0055_AA33, 48, 64'h0000_9C3A_E1D2_7B64);

    // config-selected 32-bit address, mode 3 (R4)
    addr4bEn = 1'b1;
    runXfer(1'b1, 8'h12, 32'h3C3C_C3C3, 40, 64'h00_0F1E_2D3C_4B);

    // patch requested on a dual-lane write: no patch (R7)
    addrMode = 2'd0; addrSwapEn = 1'b0; payloadLanes = 4'b0011;
    runXfer(1'b0, 8'h31, 32'h0, 32, 64'hFFFF_0000);

    // patch requested on a read: no patch, no enables (R7 R8)
    payloadLanes = 4'b0001; payloadDirOut = 1'b1;
    runXfer(1'b1, 8'h05, 32'h0, 16, 64'h1234);

    // blocked command (R9)
    dropCmd = 1'b1; addrMode = 2'd2; payloadDirOut = 1'b0; payloadSwapEn = 1'b0;
    runXfer(1'b0, 8'hC7, 32'h0012_3456, 16, 64'hABCD);

    // fresh command right after a blocked one, quad write (R11 R10 R8)
    dropCmd = 1'b0; payloadLanes = 4'b1111;
    runXfer(1'b0, 8'h32, 32'h0077_8899, 16, 64'h4321);
    chk("R11 csb follows after drop", 64'(flashCsb), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule